// File: doc/BRIEF.md
# Floppy controller phase sequencer

This block is the processor-facing engine of a floppy disk controller. It walks every command through three phases. In the command phase it collects command bytes from the processor. In the execution phase it moves data bytes between the processor (or a DMA engine) and a simple media byte stream. In the result phase it hands back status bytes. Byte counts are strict in both directions. A read-data or write-data command takes exactly nine bytes and returns exactly seven. The next command is not accepted until the last result byte has been read.

The processor sees two locations, chosen by `a0`. The main status word is read-only and can be read in any phase. The data register carries command, data and result bytes. The `dma_en` input selects one of two transfer handshakes for each command:

- **DMA mode:** a request line is raised for each byte, and an acknowledge together with a strobe completes the transfer.
- **Processor mode:** the interrupt line, or the request bit in the status word, paces each byte.

Either way, the execution phase runs until the terminal-count input is seen.

Encoding, data separation, head positioning and CRC belong to the media side. This block does not see them.

Top module: `fdc_phase_seq`

## Requirements
- R1: After reset the status word reads 0x80 (bit 7 request-for-master set; bit 6 direction, bit 5 non-DMA execution and bit 4 busy all clear). `intr`, `drq` and `med_out_valid` are low.
- R2: An opcode whose low five bits are 00110 (read) or 00101 (write) starts a nine-byte command, taken in fixed order. The bytes are opcode, head/drive byte, C, H, R, N, then three bytes that are counted but not used. From the first byte onward the status word shows busy (0x90). After the ninth byte the execution phase starts; for a processor-mode read, before the first byte arrives, the status word reads 0x70.
- R3: Any other opcode skips execution. It yields a single result byte 0x80, the status word reads 0xD0, no interrupt is raised, and after that one read the block is idle again (0x80).
- R4: In a processor-mode read, each byte taken from the media stream raises `intr` and status bit 7 (status 0xF0). A data-register read returns that byte and drops `intr`.
- R5: In a processor-mode write, the block requests each byte with `intr` and status 0xB0. Each data-register write appears once on `med_out_data` with a one-cycle `med_out_valid` pulse on the next cycle.
- R6: In DMA mode `intr` stays low throughout execution. Status bits 7 and 5 stay clear (0x50 for a read, 0x10 for a write). `drq` rises for each byte, and it is low in the cycle after an access made with `dack_n` low and the direction's strobe low.
- R7: Terminal count seen during execution ends the phase. On the next cycle the result phase begins, `intr` is high and the status word reads 0xD0. A transfer made in the same cycle as terminal count still completes.
- R8: A read or write command returns seven result bytes in this order:
  - byte 1: the head/drive byte's low three bits, with all other bits zero;
  - bytes 2 and 3: 0x00 and 0x00;
  - bytes 4 to 7: the command's C, H, R and N bytes.
- R9: The first result-byte read clears `intr`.
- R10: Data-register writes during the result phase are ignored. The result sequence and the status word are unaffected. After the last result byte the status word returns to 0x80 and a new command is accepted.
- R11: A data-register read in the command phase returns 0x00 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Processor chip select, active low |
| a0 | input | 1 | 0 = status word, 1 = data register |
| rd_n | input | 1 | Read strobe, active low, one access per low cycle |
| wr_n | input | 1 | Write strobe, active low, one access per low cycle |
| din | input | 8 | Processor / DMA write data |
| dout | output | 8 | Read data (status word or data register, selected by `a0`) |
| dma_en | input | 1 | 1 = DMA handshake during execution |
| drq | output | 1 | DMA request |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc | input | 1 | Terminal count, ends execution |
| intr | output | 1 | Interrupt |
| med_in_valid | input | 1 | Media byte available |
| med_in_data | input | 8 | Media byte |
| med_in_take | output | 1 | Media byte consumed this cycle |
| med_out_valid | output | 1 | One-cycle pulse: byte for media |
| med_out_data | output | 8 | Byte for media |

## Verification
The hardest state to reach is a transfer that coincides with the end of execution. In DMA mode, the last acknowledge and terminal count arrive in the same cycle, and the byte must still be delivered before the result phase opens. The bench drives `dack_n`, the strobe and `tc` together on one clock. It then checks the returned byte, the dropped request and the raised interrupt. A second case is a stray data write partway through the result sequence. It is injected after three result bytes have been read, and the remaining bytes must still come out in order.

// File: rtl/fdc_seq_pkg.sv
`timescale 1ns/1ps
package fdc_seq_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_EXEC = 2'd1,
    PH_RES  = 2'd2
  } phase_t;

  localparam logic [4:0] OP_READ     = 5'b00110;
  localparam logic [4:0] OP_WRITE    = 5'b00101;
  localparam logic [7:0] ST0_BAD_CMD = 8'h80;
endpackage

// File: rtl/fdc_cmd_store.sv
`timescale 1ns/1ps
// Holds the command bytes whose position lies in [KEEP_LO, KEEP_LO+KEEP_N-1].
module fdc_cmd_store #(
  parameter int DW      = 8,
  parameter int IW      = 4,
  parameter int KEEP_LO = 1,
  parameter int KEEP_N  = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IW-1:0]                widx,
  input  logic [DW-1:0]                wdata,
  output logic [KEEP_N-1:0][DW-1:0]    q
);
  for (genvar g = 0; g < KEEP_N; g++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (widx == IW'(KEEP_LO + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[g] <= '0;
      else if (slot_en) q[g] <= wdata;
    end
  end
endmodule

// File: rtl/fdc_xfer_buf.sv
`timescale 1ns/1ps
// One-byte execution-phase holding buffer and request handshake.
module fdc_xfer_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          is_read,
  input  logic          tc,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          acc,
  input  logic [DW-1:0] acc_data,
  output logic          req,
  output logic [DW-1:0] buf_data,
  output logic          take,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic          req_d, outv_d;
  logic [DW-1:0] buf_d;
  logic          done;

  assign done = req && acc;

  always_comb begin
    req_d  = req;
    buf_d  = buf_data;
    outv_d = 1'b0;
    take   = 1'b0;
    if (!active) begin
      req_d = 1'b0;
    end else begin
      if (done) begin
        req_d  = 1'b0;
        outv_d = !is_read;
      end
      if (is_read) begin
        if (!req && in_valid && !tc) begin
          take  = 1'b1;
          req_d = 1'b1;
          buf_d = in_data;
        end
      end else if (!done) begin
        req_d = 1'b1;
      end
      if (tc) req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req       <= 1'b0;
      buf_data  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      req       <= req_d;
      buf_data  <= buf_d;
      out_valid <= outv_d;
      if (outv_d) out_data <= acc_data;
    end
  end
endmodule

// File: rtl/fdc_status_mux.sv
`timescale 1ns/1ps
// Builds the status word and the result byte, and selects the read data.
module fdc_status_mux
  import fdc_seq_pkg::*;
#(
  parameter int DW     = 8,
  parameter int IW     = 4,
  parameter int KEEP_N = 5
) (
  input  phase_t                    phase,
  input  logic                      is_read,
  input  logic                      req,
  input  logic                      dma_en,
  input  logic                      busy,
  input  logic                      invalid,
  input  logic [IW-1:0]             ridx,
  input  logic [KEEP_N-1:0][DW-1:0] st,
  input  logic [DW-1:0]             buf_data,
  input  logic                      a0,
  output logic [DW-1:0]             dout
);
  logic          rqm, dio, ndm;
  logic [DW-1:0] msr, res_byte;
  logic          unused_hs;

  assign unused_hs = ^st[0][DW-1:3];

  always_comb begin
    rqm = 1'b0;
    dio = 1'b0;
    ndm = 1'b0;
    unique case (phase)
      PH_CMD:  rqm = 1'b1;
      PH_EXEC: begin
        rqm = req && !dma_en;
        dio = is_read;
        ndm = !dma_en;
      end
      PH_RES:  begin
        rqm = 1'b1;
        dio = 1'b1;
      end
      default: ;
    endcase
    msr = {rqm, dio, ndm, busy, {(DW-4){1'b0}}};
  end

  always_comb begin
    res_byte = '0;
    if (invalid) begin
      res_byte = ST0_BAD_CMD;
    end else if (ridx == '0) begin
      res_byte = {{(DW-3){1'b0}}, st[0][2:0]};
    end else begin
      for (int k = 1; k < KEEP_N; k++)
        if (ridx == IW'(k + 2)) res_byte = st[k];
    end
  end

  always_comb begin
    if (!a0)                              dout = msr;
    else if (phase == PH_RES)             dout = res_byte;
    else if (phase == PH_EXEC && is_read) dout = buf_data;
    else                                  dout = '0;
  end
endmodule

// File: rtl/fdc_phase_seq.sv
`timescale 1ns/1ps
module fdc_phase_seq
  import fdc_seq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CMD_LEN = 9,
  parameter int RES_LEN = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          a0,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic          dma_en,
  output logic          drq,
  input  logic          dack_n,
  input  logic          tc,
  output logic          intr,
  input  logic          med_in_valid,
  input  logic [DW-1:0] med_in_data,
  output logic          med_in_take,
  output logic          med_out_valid,
  output logic [DW-1:0] med_out_data
);
  localparam int IW     = $clog2(CMD_LEN + 1);
  localparam int KEEP_N = RES_LEN - 2;   // head/drive byte plus C,H,R,N

  // reset: asynchronous assert, synchronous release
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  phase_t        phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          rdc_q, rdc_d, inv_q, inv_d, irq_q, irq_d;

  logic host_wr, host_rd, in_exec, xfer_acc, cmd_we, res_last, busy;
  logic req;
  logic [DW-1:0] buf_data;
  logic [KEEP_N-1:0][DW-1:0] st;

  assign host_wr  = !cs_n && a0 && !wr_n;
  assign host_rd  = !cs_n && a0 && !rd_n;
  assign in_exec  = (phase_q == PH_EXEC);
  assign xfer_acc = dma_en ? (!dack_n && (rdc_q ? !rd_n : !wr_n))
                           : (rdc_q ? host_rd : host_wr);
  assign cmd_we   = (phase_q == PH_CMD) && host_wr;
  assign res_last = inv_q ? (idx_q == '0) : (idx_q == IW'(RES_LEN - 1));
  assign busy     = (phase_q != PH_CMD) || (idx_q != '0);

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    rdc_d   = rdc_q;
    inv_d   = inv_q;
    irq_d   = irq_q;
    unique case (phase_q)
      PH_CMD: if (host_wr) begin
        if (idx_q == '0) begin
          if (din[4:0] == OP_READ || din[4:0] == OP_WRITE) begin
            idx_d = IW'(1);
            rdc_d = (din[4:0] == OP_READ);
            inv_d = 1'b0;
          end else begin
            phase_d = PH_RES;
            inv_d   = 1'b1;
          end
        end else if (idx_q == IW'(CMD_LEN - 1)) begin
          phase_d = PH_EXEC;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      PH_EXEC: if (tc) begin
        phase_d = PH_RES;
        irq_d   = 1'b1;
        idx_d   = '0;
      end
      PH_RES: if (host_rd) begin
        irq_d = 1'b0;
        if (res_last) begin
          phase_d = PH_CMD;
          idx_d   = '0;
          inv_d   = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: phase_d = PH_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      phase_q <= PH_CMD;
      idx_q   <= '0;
      rdc_q   <= 1'b0;
      inv_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      rdc_q   <= rdc_d;
      inv_q   <= inv_d;
      irq_q   <= irq_d;
    end
  end

  fdc_cmd_store #(.DW(DW), .IW(IW), .KEEP_LO(1), .KEEP_N(KEEP_N)) store_i (
    .clk(clk), .rst_n(rs_n), .we(cmd_we), .widx(idx_q), .wdata(din), .q(st)
  );

  fdc_xfer_buf #(.DW(DW)) xfer_i (
    .clk(clk), .rst_n(rs_n), .active(in_exec), .is_read(rdc_q), .tc(tc),
    .in_valid(med_in_valid), .in_data(med_in_data), .acc(xfer_acc), .acc_data(din),
    .req(req), .buf_data(buf_data), .take(med_in_take),
    .out_valid(med_out_valid), .out_data(med_out_data)
  );

  fdc_status_mux #(.DW(DW), .IW(IW), .KEEP_N(KEEP_N)) stat_i (
    .phase(phase_q), .is_read(rdc_q), .req(req), .dma_en(dma_en), .busy(busy),
    .invalid(inv_q), .ridx(idx_q), .st(st), .buf_data(buf_data), .a0(a0), .dout(dout)
  );

  assign drq  = in_exec && dma_en && req;
  assign intr = irq_q || (in_exec && !dma_en && req);
endmodule

// File: rtl/fdc_phase_seq_chk.sv
`timescale 1ns/1ps
module fdc_phase_seq_chk
  import fdc_seq_pkg::*;
#(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input phase_t        phase,
  input logic [IW-1:0] idx,
  input logic          is_read,
  input logic          cs_n,
  input logic          a0,
  input logic          rd_n,
  input logic          wr_n,
  input logic          dma_en,
  input logic          dack_n,
  input logic          tc,
  input logic          drq,
  input logic          intr,
  input logic          med_out_valid
);
  // R7
  exec_tc_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && tc) |=> (intr && phase == PH_RES));

  // R6
  dma_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && dma_en) |-> !intr);

  // R6
  drq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && !dack_n && (is_read ? !rd_n : !wr_n)) |=> !drq);

  // R9
  res_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RES && !cs_n && a0 && !rd_n) |=> !intr);

  // R10
  res_wr_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RES && !cs_n && a0 && !wr_n && rd_n) |=> ($stable(phase) && $stable(idx)));

  // R5
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    med_out_valid |=> !med_out_valid);
endmodule

bind fdc_phase_seq fdc_phase_seq_chk #(.IW(IW)) chk_i (
  .clk(clk), .rst_n(rs_n), .phase(phase_q), .idx(idx_q), .is_read(rdc_q),
  .cs_n(cs_n), .a0(a0), .rd_n(rd_n), .wr_n(wr_n), .dma_en(dma_en),
  .dack_n(dack_n), .tc(tc), .drq(drq), .intr(intr), .med_out_valid(med_out_valid)
);

// File: tb/fdc_phase_seq_tb.sv
`timescale 1ns/1ps
module fdc_phase_seq_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, cs_n, a0, rd_n, wr_n, dma_en, dack_n, tc;
  logic [7:0] din, dout, med_in_data, med_out_data;
  logic       drq, intr, med_in_valid, med_in_take, med_out_valid;

  fdc_phase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .a0(a0), .rd_n(rd_n), .wr_n(wr_n),
    .din(din), .dout(dout), .dma_en(dma_en), .drq(drq), .dack_n(dack_n), .tc(tc),
    .intr(intr), .med_in_valid(med_in_valid), .med_in_data(med_in_data),
    .med_in_take(med_in_take), .med_out_valid(med_out_valid), .med_out_data(med_out_data)
  );

  int n_chk = 0;
  int n_fail = 0;

  // media source model
  logic       med_clr;
  logic [3:0] med_cnt, med_lim;
  always_ff @(posedge clk)
    if (med_clr) med_cnt <= '0;
    else if (med_in_take) med_cnt <= med_cnt + 1'b1;
  assign med_in_valid = (med_cnt < med_lim);
  assign med_in_data  = 8'(8'h11 * (med_cnt + 1));

  // scoreboard for bytes sent to the media side
  logic [7:0] exp_q[$];
  always @(negedge clk) begin
    if (med_out_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5: unexpected media byte %02h, expected none", med_out_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (med_out_data !== e) begin
          n_fail++;
          $display("FAIL R5: media byte %02h, expected %02h", med_out_data, e);
        end
      end
    end
  end

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", rq, act, exp);
    end
  endtask

  task automatic host_write(input logic adr, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; a0 = adr; din = d; wr_n = 1'b0;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic host_read(input logic adr, output logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; a0 = adr; rd_n = 1'b0;
    #1 d = dout;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic msr(output logic [7:0] d);
    a0 = 1'b0; #1 d = dout;
  endtask

  task automatic dma_read(input logic last, output logic [7:0] d);
    @(negedge clk); a0 = 1'b1; dack_n = 1'b0; rd_n = 1'b0; tc = last;
    #1 d = dout;
    @(negedge clk); dack_n = 1'b1; rd_n = 1'b1; tc = 1'b0;
  endtask

  task automatic dma_write(input logic last, input logic [7:0] d);
    exp_q.push_back(d);
    @(negedge clk); dack_n = 1'b0; wr_n = 1'b0; din = d; tc = last;
    @(negedge clk); dack_n = 1'b1; wr_n = 1'b1; tc = 1'b0;
  endtask

  task automatic pulse_tc();
    @(negedge clk); tc = 1'b1;
    @(negedge clk); tc = 1'b0;
  endtask

  task automatic wait_req(input string rq);
    int n = 0;
    while (!(dma_en ? drq : intr) && n < 30) begin
      @(negedge clk); n++;
    end
    chk(rq, 8'(dma_en ? drq : intr), 8'd1);
  endtask

  task automatic issue_cmd(input logic [7:0] op, input logic [7:0] hs,
                           input logic [7:0] c, input logic [7:0] h,
                           input logic [7:0] r, input logic [7:0] n);
    logic [7:0] m;
    host_write(1'b1, op);
    msr(m); chk("R2 busy after opcode", m, 8'h90);
    host_write(1'b1, hs);
    host_write(1'b1, c);
    host_write(1'b1, h);
    host_write(1'b1, r);
    host_write(1'b1, n);
    host_write(1'b1, 8'h09);
    host_write(1'b1, 8'h2A);
    host_write(1'b1, 8'hFF);
  endtask

  // reads all seven result bytes; optionally injects a stray write after three
  task automatic read_results(input logic [7:0] hs, input logic [7:0] c,
                              input logic [7:0] h, input logic [7:0] r,
                              input logic [7:0] n, input logic stray);
    logic [7:0] d, m;
    logic [7:0] exp [7];
    exp[0] = {5'b0, hs[2:0]}; exp[1] = 8'h00; exp[2] = 8'h00;
    exp[3] = c; exp[4] = h; exp[5] = r; exp[6] = n;
    for (int k = 0; k < 7; k++) begin
      if (stray && k == 3) begin
        host_write(1'b1, 8'h46);
        msr(m); chk("R10 stray write ignored, status", m, 8'hD0);
      end
      host_read(1'b1, d);
      chk("R8 result byte", d, exp[k]);
      if (k == 0) chk("R9 intr cleared by first result read", 8'(intr), 8'd0);
    end
    msr(m); chk("R10 idle after last result", m, 8'h80);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d, m;
    rst_n = 1'b0; cs_n = 1'b1; a0 = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    din = '0; dma_en = 1'b0; dack_n = 1'b1; tc = 1'b0;
    med_clr = 1'b1; med_lim = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; med_clr = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    msr(m); chk("R1 status after reset", m, 8'h80);
    chk("R1 intr after reset", 8'(intr), 8'd0);
    chk("R1 drq after reset", 8'(drq), 8'd0);
    chk("R1 med_out_valid after reset", 8'(med_out_valid), 8'd0);

    // R11 data read in command phase
    host_read(1'b1, d); chk("R11 data read in command phase", d, 8'h00);
    msr(m); chk("R11 status unchanged", m, 8'h80);

    // R3 invalid opcode
    host_write(1'b1, 8'h1F);
    msr(m); chk("R3 status after bad opcode", m, 8'hD0);
    chk("R3 no interrupt", 8'(intr), 8'd0);
    host_read(1'b1, d); chk("R3 single result byte", d, 8'h80);
    msr(m); chk("R3 idle again", m, 8'h80);

    // processor-mode read: three bytes
    med_lim = 4'd3;
    issue_cmd(8'h46, 8'h05, 8'h0A, 8'h01, 8'h03, 8'h02);
    msr(m); chk("R2 execution entered (read, no byte yet)", m, 8'h70);
    for (int b = 0; b < 3; b++) begin
      wait_req("R4 intr for read byte");
      msr(m); chk("R4 status with byte ready", m, 8'hF0);
      host_read(1'b1, d); chk("R4 read byte value", d, 8'(8'h11 * (b + 1)));
      chk("R4 intr dropped after read", 8'(intr), 8'd0);
    end
    pulse_tc();
    chk("R7 intr after terminal count", 8'(intr), 8'd1);
    msr(m); chk("R7 status in result phase", m, 8'hD0);
    host_write(1'b1, 8'hEE);
    msr(m); chk("R10 write ignored at result start", m, 8'hD0);
    chk("R10 intr kept after ignored write", 8'(intr), 8'd1);
    read_results(8'h05, 8'h0A, 8'h01, 8'h03, 8'h02, 1'b1);

    // processor-mode write: two bytes
    issue_cmd(8'h45, 8'h02, 8'h10, 8'h00, 8'h01, 8'h03);
    for (int b = 0; b < 2; b++) begin
      wait_req("R5 intr requests write byte");
      msr(m); chk("R5 status requesting byte", m, 8'hB0);
      exp_q.push_back(8'(8'hA5 ^ b));
      host_write(1'b1, 8'(8'hA5 ^ b));
      chk("R5 intr dropped after write", 8'(intr), 8'd0);
    end
    repeat (2) @(negedge clk);
    pulse_tc();
    chk("R7 intr after terminal count (write)", 8'(intr), 8'd1);
    read_results(8'h02, 8'h10, 8'h00, 8'h01, 8'h03, 1'b0);

    // DMA read: two bytes, last acknowledge with terminal count
    dma_en = 1'b1;
    med_clr = 1'b1; @(negedge clk); med_clr = 1'b0; med_lim = 4'd2;
    issue_cmd(8'h06, 8'h07, 8'h21, 8'h01, 8'h05, 8'h02);
    wait_req("R6 drq for dma read byte");
    chk("R6 no intr in dma execution", 8'(intr), 8'd0);
    msr(m); chk("R6 status dma read", m, 8'h50);
    dma_read(1'b0, d); chk("R6 dma read byte 1", d, 8'h11);
    chk("R6 drq low after acknowledge", 8'(drq), 8'd0);
    wait_req("R6 drq for second dma byte");
    dma_read(1'b1, d); chk("R7 byte with terminal count", d, 8'h22);
    chk("R7 intr after dma terminal count", 8'(intr), 8'd1);
    chk("R6 drq low after final acknowledge", 8'(drq), 8'd0);
    read_results(8'h07, 8'h21, 8'h01, 8'h05, 8'h02, 1'b0);

    // DMA write: two bytes, second with terminal count
    issue_cmd(8'hC5, 8'h01, 8'h30, 8'h01, 8'h09, 8'h01);
    wait_req("R6 drq for dma write byte");
    msr(m); chk("R6 status dma write", m, 8'h10);
    chk("R6 no intr in dma write", 8'(intr), 8'd0);
    dma_write(1'b0, 8'h3C);
    chk("R6 drq low after write acknowledge", 8'(drq), 8'd0);
    wait_req("R6 drq again");
    dma_write(1'b1, 8'hC3);
    chk("R7 intr after dma write end", 8'(intr), 8'd1);
    @(negedge clk);
    chk("R5 all media bytes delivered", 8'(exp_q.size()), 8'd0);
    read_results(8'h01, 8'h30, 8'h01, 8'h09, 8'h01, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule